// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy Mapping Detection

This block steers the four interrupt pins (A, B, C, D) of every device on a small PCI backplane onto four system interrupt lines. Each device asserts a level request per pin; the router computes, for every active request, which system line it belongs to and drives each line high while any request routed to it is active. The lines are registered, so they follow the requests one clock later.

Two wiring variants are supported, chosen by a static select pin. In the first variant the router also snoops configuration write transactions. Old guest software expects an identity pin-to-line mapping, while correct software expects a rotated (swizzled) mapping. The first write to a device's interrupt-line register, on a slot where the two mappings differ, tells the router which kind of software is running. The value 27 marks legacy software and locks the router into the identity mapping. Any other value locks it into the swizzled mapping. Until that write arrives the swizzled mapping is assumed, and once a decision has been made it holds until reset. In the second variant detection is off and a rotated mapping with a different offset is always used.

The configuration snoop is a plain strobe with address and data. The router only observes these transactions and never stalls them, so the interface has no ready signal and no back-pressure.

Top module: `pci_irq_router`

## Requirements
- R1: After reset all four system lines are low and the mapping mode is the assumed-correct (swizzled) one.
- R2: With `variant_sel` low and no legacy decision, a request on pin p (A=0, B=1, C=2, D=3) of slot s drives line (s + p + 2) mod 4. Request bit 4*k+p belongs to slot SLOT_BASE+k.
- R3: With `variant_sel` high, a request on pin p of slot s always drives line (s + p + 3) mod 4.
- R4: Each system line is the OR of all requests currently routed to it.
- R5: A change in the requests reaches `irq_out` exactly one clock edge later.
- R6: With `variant_sel` low, while undecided, a write strobe whose address bits [7:0] equal 0x3C and whose slot (address bits [15:11]) has slot mod 4 not equal to 2, carrying data 27, selects the legacy mode. In legacy mode pin p drives line p. The new mapping appears on `irq_out` two edges after the write.
- R7: A qualifying write with any data other than 27 selects the forced-correct mode, which keeps the R2 mapping.
- R8: Once legacy or forced-correct mode is chosen, no later write changes it until reset.
- R9: Writes to slots with slot mod 4 equal to 2 do not decide the mode. A later qualifying write to another slot still decides it.
- R10: Writes to offsets other than 0x3C, and address/data presented without the strobe, leave the mode undecided.
- R11: While `variant_sel` is high, configuration writes leave the mode untouched. The mode is still undecided when the pin returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_sel | input | 1 | Static wiring variant: 0 = offset 2 with detection, 1 = offset 3 without |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 16 | Configuration address; [15:11] slot, [10:8] function, [7:0] register offset |
| cfg_wdata | input | 8 | Byte written to the addressed register |
| slot_irq_req | input | 4*NUM_SLOTS | Level requests; bit 4*k+p is pin p of slot SLOT_BASE+k |
| irq_out | output | 4 | Registered level-sensitive system interrupt lines |

## Verification
The hardest condition to reach from the ports is the mode register's hidden state. It is invisible except through routing, and the swizzled routing looks the same whether the router is undecided or locked into forced-correct. The stimulus therefore follows every ignored write (wrong slot, wrong offset, no strobe, second variant) with a decisive write of 27 to a qualifying slot. Only a router that was still undecided switches to the identity mapping, and a single request on slot 28 pin A tells the two mappings apart (line 2 versus line 0).

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_PINS = 4;
  localparam int NUM_LINES = 4;
  localparam logic [7:0] IRQ_LINE_REG = 8'h3C;
  localparam logic [7:0] LEGACY_TOKEN = 8'd27;
  localparam logic [1:0] SKIP_SLOT_LO = 2'd2;

  typedef enum logic [1:0] {
    MODE_UNDECIDED = 2'd0,
    MODE_LEGACY    = 2'd1,
    MODE_FORCED    = 2'd2
  } map_mode_e;
endpackage

// File: rtl/pirq_detect.sv
module pirq_detect
  import pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       variant_sel,
  input  logic       wr_en,
  input  logic [7:0] reg_off,
  input  logic [1:0] slot_lo,
  input  logic [7:0] wdata,
  output map_mode_e  mode
);
  logic      qualifies;
  map_mode_e mode_d;

  always_comb begin
    qualifies = wr_en && !variant_sel && (reg_off == IRQ_LINE_REG)
                && (mode == MODE_UNDECIDED) && (slot_lo != SKIP_SLOT_LO);
    mode_d = mode;
    if (qualifies) begin
      mode_d = (wdata == LEGACY_TOKEN) ? MODE_LEGACY : MODE_FORCED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_UNDECIDED;
    else        mode <= mode_d;
  end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int SLOT = 28
) (
  input  logic                 legacy,
  input  logic                 variant_sel,
  input  logic [NUM_PINS-1:0]  req,
  output logic [NUM_LINES-1:0] lines
);
  localparam logic [1:0] SLOT_LO = 2'(SLOT % 4);

  logic [1:0] offset;
  assign offset = variant_sel ? 2'd3 : 2'd2;

  always_comb begin
    lines = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      logic [1:0] idx;
      if (legacy && !variant_sel) idx = 2'(p);
      else                        idx = 2'(SLOT_LO + 2'(p) + offset);
      if (req[p]) lines[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_BASE = 28
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        variant_sel,
  input  logic                        cfg_wr_en,
  input  logic [15:0]                 cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  input  logic [NUM_PINS*NUM_SLOTS-1:0] slot_irq_req,
  output logic [NUM_LINES-1:0]        irq_out
);
  map_mode_e                   map_mode;
  logic [NUM_LINES-1:0]        slot_lines [NUM_SLOTS];
  logic [NUM_LINES-1:0]        lines_d;
  logic                        unused_addr;

  assign unused_addr = ^{cfg_addr[15:13], cfg_addr[10:8]};

  pirq_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .variant_sel (variant_sel),
    .wr_en       (cfg_wr_en),
    .reg_off     (cfg_addr[7:0]),
    .slot_lo     (cfg_addr[12:11]),
    .wdata       (cfg_wdata),
    .mode        (map_mode)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    pirq_swizzle #(.SLOT(SLOT_BASE + k)) u_swz (
      .legacy      (map_mode == MODE_LEGACY),
      .variant_sel (variant_sel),
      .req         (slot_irq_req[k*NUM_PINS +: NUM_PINS]),
      .lines       (slot_lines[k])
    );
  end

  always_comb begin
    lines_d = '0;
    for (int k = 0; k < NUM_SLOTS; k++) lines_d = lines_d | slot_lines[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= lines_d;
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             variant_sel,
  input logic             cfg_wr_en,
  input logic [15:0]      cfg_addr,
  input logic [7:0]       cfg_wdata,
  input logic [REQ_W-1:0] slot_irq_req,
  input logic [3:0]       irq_out,
  input logic [1:0]       mode
);
  AST_DECISION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_UNDECIDED) |=> (mode == $past(mode))); // R8

  AST_VARIANT_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    variant_sel |=> $stable(mode)); // R11

  AST_SKIP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr[12:11] == 2'd2) |=> $stable(mode)); // R9

  AST_LEGACY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UNDECIDED && cfg_wr_en && !variant_sel && cfg_addr[7:0] == 8'h3C
     && cfg_addr[12:11] != 2'd2 && cfg_wdata == 8'd27) |=> (mode == MODE_LEGACY)); // R6

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_irq_req == '0) |=> (irq_out == '0)); // R4

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_irq_req) == 1) |=> ($countones(irq_out) == 1)); // R5
endmodule

bind pci_irq_router pirq_checker #(.REQ_W(NUM_PINS*NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .variant_sel  (variant_sel),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .slot_irq_req (slot_irq_req),
  .irq_out      (irq_out),
  .mode         (map_mode)
);

// File: tb/pci_irq_router_bench.sv
module pci_irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4;
  localparam int SBASE = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant_sel = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] req = '0;
  logic [3:0]  irq_out;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NSLOT), .SLOT_BASE(SBASE)) u_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .slot_irq_req(req), .irq_out(irq_out)
  );

  function automatic logic [3:0] model(input logic [15:0] r, input bit legacy, input bit v1);
    logic [3:0] o = '0;
    for (int k = 0; k < NSLOT; k++)
      for (int p = 0; p < 4; p++)
        if (r[k*4+p]) begin
          if (legacy && !v1) o[p] = 1'b1;
          else o[(SBASE + k + p + (v1 ? 3 : 2)) % 4] = 1'b1;
        end
    return o;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_out=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit v1);
    @(negedge clk);
    rst_n = 1'b0; variant_sel = v1; req = '0; cfg_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input int slot, input logic [7:0] off, input logic [7:0] data, input bit strobe);
    @(negedge clk);
    cfg_addr = {5'(slot), 3'd0, off};
    cfg_wdata = data;
    cfg_wr_en = strobe;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic apply(input logic [15:0] r);
    @(negedge clk);
    req = r;
    repeat (2) @(negedge clk);
  endtask

  task automatic probe(input string tag, input bit legacy, input bit v1);
    apply(16'h0001);
    check(tag, irq_out, model(16'h0001, legacy, v1));
    apply(16'h0000);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 lines low after reset", irq_out, 4'b0000);
    probe("R1 undecided mode swizzles", 1'b0, 1'b0);
  endtask

  task automatic t_variant0();
    do_reset(1'b0);
    for (int i = 0; i < 16; i++) begin
      apply(16'(1 << i));
      check("R2 single request offset 2", irq_out, model(16'(1 << i), 1'b0, 1'b0));
    end
  endtask

  task automatic t_variant1();
    do_reset(1'b1);
    for (int i = 0; i < 16; i++) begin
      apply(16'(1 << i));
      check("R3 single request offset 3", irq_out, model(16'(1 << i), 1'b0, 1'b1));
    end
  endtask

  task automatic t_or();
    do_reset(1'b0);
    apply(16'hFFFF); check("R4 all requests", irq_out, 4'hF);
    apply(16'h0003); check("R4 two pins", irq_out, 4'b1100);
    apply(16'h0081); check("R4 two sources one line", irq_out, 4'b0100);
    apply(16'h0000); check("R4 all released", irq_out, 4'b0000);
  endtask

  task automatic t_latency();
    do_reset(1'b0);
    @(negedge clk);
    req = 16'h0001;
    #1 check("R5 before edge", irq_out, 4'b0000);
    @(negedge clk);
    check("R5 after one edge", irq_out, 4'b0100);
    req = 16'h0000;
    @(negedge clk);
    check("R5 release after one edge", irq_out, 4'b0000);
  endtask

  task automatic t_legacy();
    do_reset(1'b0);
    @(negedge clk);
    req = 16'h0001;
    cfg_addr = {5'd28, 3'd0, 8'h3C}; cfg_wdata = 8'd27; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R6 old mapping one edge after write", irq_out, 4'b0100);
    @(negedge clk);
    check("R6 identity two edges after write", irq_out, 4'b0001);
    apply(16'h2480);
    check("R6 identity pattern", irq_out, model(16'h2480, 1'b1, 1'b0));
  endtask

  task automatic t_forced();
    do_reset(1'b0);
    cfg_write(28, 8'h3C, 8'd5, 1'b1);
    cfg_write(29, 8'h3C, 8'd27, 1'b1);
    probe("R7 forced mode keeps swizzle", 1'b0, 1'b0);
  endtask

  task automatic t_sticky();
    do_reset(1'b0);
    cfg_write(31, 8'h3C, 8'd27, 1'b1);
    cfg_write(28, 8'h3C, 8'd10, 1'b1);
    probe("R8 legacy survives later write", 1'b1, 1'b0);
  endtask

  task automatic t_skip_slot();
    do_reset(1'b0);
    cfg_write(30, 8'h3C, 8'd27, 1'b1);
    probe("R9 slot mod 4 == 2 ignored", 1'b0, 1'b0);
    cfg_write(30, 8'h3C, 8'd9, 1'b1);
    cfg_write(31, 8'h3C, 8'd27, 1'b1);
    probe("R9 later qualifying write decides", 1'b1, 1'b0);
  endtask

  task automatic t_other_offset();
    do_reset(1'b0);
    cfg_write(28, 8'h3D, 8'd27, 1'b1);
    cfg_write(28, 8'h00, 8'd27, 1'b1);
    cfg_write(28, 8'h3C, 8'd27, 1'b0);
    probe("R10 non-qualifying writes ignored", 1'b0, 1'b0);
    cfg_write(28, 8'h3C, 8'd27, 1'b1);
    probe("R10 mode was still undecided", 1'b1, 1'b0);
  endtask

  task automatic t_variant1_nodetect();
    do_reset(1'b1);
    cfg_write(28, 8'h3C, 8'd7, 1'b1);
    probe("R11 variant 1 offset 3 kept", 1'b0, 1'b1);
    @(negedge clk);
    variant_sel = 1'b0;
    cfg_write(29, 8'h3C, 8'd27, 1'b1);
    probe("R11 mode still undecided after variant 1 writes", 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_variant0();
    t_variant1();
    t_or();
    t_latency();
    t_legacy();
    t_forced();
    t_sticky();
    t_skip_slot();
    t_other_offset();
    t_variant1_nodetect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule